// File: doc/BRIEF.md
# Multichannel Violation Counter Bank

This block keeps one saturating event counter per line channel. Every cycle in which a channel's violation pulse input is high, that channel's counter goes up by one. Fourteen channels and sixteen-bit counters are the default sizes. Software never reads a counter directly. It first writes a channel index into a select register. It then raises a snapshot bit, which copies that channel's count into one shared sixteen-bit holding register. The holding register is read one byte at a time, and a byte-select bit picks which byte.

Clearing also acts on one channel at a time. The clear bit in the control register has to stay set for a minimum number of consecutive clock cycles, given by a parameter, before the selected counter is zeroed. If the select register holds an index outside the channel range, snapshot and clear do nothing.

The register port is a plain synchronous interface with a write strobe, a two-bit address, write data and combinational read data. It has no handshake.

Top module: `viol_count_bank`

## Requirements
- R1: After reset, the select register, the control register, the holding register and every counter are zero, so every address reads 0x00.
- R2: A channel's counter increases by exactly one at each rising clock edge where its violation pulse is high, and holds its value otherwise.
- R3: A counter that has reached its all-ones value stays there on further pulses, with no wrap.
- R4: The snapshot bit is control bit 1. A 0-to-1 change of this bit loads the holding register with the selected channel's count at the next edge. Leaving the bit at 1, or writing 1 again while it is already 1, does not reload the register. Counting goes on while the holding register is read.
- R5: Address 2 reads the low byte of the holding register when control bit 2 is 0, and the high byte when it is 1.
- R6: The clear bit is control bit 0. When it has been 1 for CLR_HOLD_CYC consecutive cycles with a valid channel selected, the selected counter is zeroed. A shorter pulse has no effect. Rewriting the select register restarts the hold count.
- R7: If a clear and a violation pulse fall in the same cycle on one channel, the counter ends at zero.
- R8: A select value of NUM_CH or more addresses no channel. Snapshot then leaves the holding register unchanged, and clear changes no counter.
- R9: Address 0 reads the select index in bits 3:0. Address 1 reads the control bits in bits 2:0. Address 3 reads zero. All other bits read 0, and written values in those bits are discarded.
- R10: Snapshot and clear act only on the selected channel. The counts of all other channels are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| viol_pulse | input | NUM_CH | One violation pulse per channel, counted while high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 select, 1 control, 2 held byte |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |

## Verification
The bench builds the block with the full fourteen channels and sixteen-bit counters, but shortens CLR_HOLD_CYC to 4. With a short hold time the clear boundary can be tested one cycle below and exactly at the threshold. Driving every channel for a little over 65,535 cycles brings saturation and the high byte 0xFF within reach. Expected counts come from an arithmetic model in the bench. Every channel and both out-of-range indices are swept.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
  localparam logic [1:0] A_CHSEL = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_HOLD  = 2'd2;
  localparam int HOLD_W = 16;

  // Control register bits: [2] high byte select, [1] snapshot, [0] clear.
  typedef struct packed {
    logic byte_hi;
    logic snap;
    logic clr;
  } ctrl_t;
endpackage

// File: rtl/vcb_sat_counter.sv
module vcb_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   count <= '0;
    else if (clr)                 count <= '0;
    else if (inc && count != CMAX) count <= count + CNT_W'(1);
  end

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CMAX && !clr) |=> count == CMAX);
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && count != CMAX) |=> count == $past(count) + CNT_W'(1));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(count));
endmodule

// File: rtl/vcb_ctrl_regs.sv
module vcb_ctrl_regs
  import vcb_pkg::*;
#(
  parameter int NUM_CH       = 14,
  parameter int SEL_W        = 4,
  parameter int CLR_HOLD_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [SEL_W-1:0] sel,
  output ctrl_t            ctrl,
  output logic             snap_fire,
  output logic             clr_fire
);
  localparam int HC_W = $clog2(CLR_HOLD_CYC) + 1;
  localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(CLR_HOLD_CYC - 1);

  logic            snap_q;
  logic [HC_W-1:0] hold_cnt;
  logic            sel_wr, ctrl_wr, sel_valid;

  assign sel_wr    = we && (addr == A_CHSEL);
  assign ctrl_wr   = we && (addr == A_CTRL);
  assign sel_valid = int'(sel) < NUM_CH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel      <= '0;
      ctrl     <= '0;
      snap_q   <= 1'b0;
      hold_cnt <= '0;
    end else begin
      if (sel_wr)  sel  <= wdata[SEL_W-1:0];
      if (ctrl_wr) ctrl <= ctrl_t'(wdata[2:0]);
      snap_q <= ctrl.snap;
      // Count consecutive cycles of a set clear bit; saturate at the threshold.
      if (!ctrl.clr || sel_wr)       hold_cnt <= '0;
      else if (hold_cnt != HOLD_LAST) hold_cnt <= hold_cnt + HC_W'(1);
    end
  end

  assign snap_fire = ctrl.snap && !snap_q && sel_valid;
  assign clr_fire  = ctrl.clr && sel_valid && (hold_cnt == HOLD_LAST);

  p_snap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire |=> !snap_fire);

  generate
    if (CLR_HOLD_CYC > 1) begin : g_hold_chk
      p_clr_min_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fire |-> $past(ctrl.clr));
    end
  endgenerate
endmodule

// File: rtl/vcb_readout.sv
module vcb_readout
  import vcb_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int CNT_W  = 16,
  parameter int SEL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH*CNT_W-1:0] counts,
  input  logic [SEL_W-1:0]        sel,
  input  logic                    snap_fire,
  input  logic                    byte_hi,
  output logic [7:0]              hold_byte
);
  logic [CNT_W-1:0]  picked;
  logic [HOLD_W-1:0] hold;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (int'(sel) == i) picked = counts[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         hold <= '0;
    else if (snap_fire) hold <= HOLD_W'(picked);
  end

  assign hold_byte = byte_hi ? hold[15:8] : hold[7:0];

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_fire |=> $stable(hold));
  p_hold_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    snap_fire |=> hold == HOLD_W'($past(picked)));
endmodule

// File: rtl/viol_count_bank.sv
module viol_count_bank
  import vcb_pkg::*;
#(
  parameter int NUM_CH       = 14,
  parameter int CNT_W        = 16,
  parameter int SEL_W        = 4,
  parameter int CLR_HOLD_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] viol_pulse,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata
);
  logic [SEL_W-1:0]        sel;
  ctrl_t                   ctrl;
  logic                    snap_fire, clr_fire;
  logic [NUM_CH-1:0]       clr_vec;
  logic [NUM_CH*CNT_W-1:0] counts;
  logic [7:0]              hold_byte;

  vcb_ctrl_regs #(
    .NUM_CH(NUM_CH), .SEL_W(SEL_W), .CLR_HOLD_CYC(CLR_HOLD_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sel(sel), .ctrl(ctrl), .snap_fire(snap_fire), .clr_fire(clr_fire)
  );

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      assign clr_vec[g] = clr_fire && (int'(sel) == g);
      vcb_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(viol_pulse[g]), .clr(clr_vec[g]),
        .count(counts[g*CNT_W +: CNT_W])
      );
    end
  endgenerate

  vcb_readout #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .counts(counts), .sel(sel),
    .snap_fire(snap_fire), .byte_hi(ctrl.byte_hi), .hold_byte(hold_byte)
  );

  always_comb begin
    case (reg_addr)
      A_CHSEL: reg_rdata = 8'(sel);
      A_CTRL:  reg_rdata = {5'b0, ctrl};
      A_HOLD:  reg_rdata = hold_byte;
      default: reg_rdata = 8'h00;
    endcase
  end

  p_clr_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));
endmodule

// File: tb/sim_viol_count_bank.sv
module sim_viol_count_bank;
  localparam int NCH = 14;
  localparam int HC  = 4;
  localparam int CMAX = 65535;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] viol = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt [NCH];

  always #5 clk = ~clk;

  viol_count_bank #(.NUM_CH(NCH), .CNT_W(16), .SEL_W(4), .CLR_HOLD_CYC(HC)) u0 (
    .clk(clk), .rst_n(rst_n), .viol_pulse(viol), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input int act, input int expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    for (int c = 0; c < NCH; c++)
      if (viol[c] && exp_cnt[c] < CMAX) exp_cnt[c]++;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a; #1; v = int'(reg_rdata);
  endtask

  task automatic read_count(input int ch, output int v);
    int lo, hi;
    wr(2'd0, 8'(ch));
    wr(2'd1, 8'h00);
    wr(2'd1, 8'h02);
    cyc();
    wr(2'd1, 8'h00);
    rd(2'd2, lo);
    wr(2'd1, 8'h04);
    rd(2'd2, hi);
    wr(2'd1, 8'h00);
    v = (hi << 8) | lo;
  endtask

  task automatic check_all(input string tag);
    int v;
    for (int c = 0; c < NCH; c++) begin
      read_count(c, v);
      chk(v, exp_cnt[c], $sformatf("%s ch%0d", tag, c));
    end
  endtask

  task automatic hold_clear(input int ch, input int cycles);
    wr(2'd0, 8'(ch));
    wr(2'd1, 8'h01);
    for (int i = 0; i < cycles - 1; i++) cyc();
    wr(2'd1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, old;
    for (int c = 0; c < NCH; c++) exp_cnt[c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state across all addresses and counters
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v, 0, $sformatf("R1 reset read addr%0d", a));
    end
    check_all("R1 reset count");

    // R2 / R10: distinct pulse rates per channel
    for (int k = 1; k <= 60; k++) begin
      for (int c = 0; c < NCH; c++) viol[c] = ((k % (c + 2)) == 0);
      cyc();
    end
    viol = '0;
    for (int c = 0; c < NCH; c++) chk(exp_cnt[c], 60 / (c + 2), "R2 model arithmetic");
    check_all("R2 rate sweep");

    // R5: high byte becomes non-zero
    viol[3] = 1'b1;
    repeat (300) cyc();
    viol = '0;
    read_count(3, v);
    chk(v >> 8, exp_cnt[3] >> 8, "R5 high byte");
    chk(v & 255, exp_cnt[3] & 255, "R5 low byte");

    // R9: register readback and discarded bits
    wr(2'd0, 8'hF7);
    rd(2'd0, v); chk(v, 8'h07, "R9 select readback");
    wr(2'd1, 8'hF8);
    rd(2'd1, v); chk(v, 0, "R9 control upper bits");
    wr(2'd1, 8'h04);
    rd(2'd1, v); chk(v, 4, "R9 control byte bit");
    rd(2'd3, v); chk(v, 0, "R9 unused address");
    wr(2'd1, 8'h00);

    // R4: edge-triggered snapshot, counting continues
    wr(2'd0, 8'd5);
    wr(2'd1, 8'h02);
    cyc();
    rd(2'd2, v); chk(v, exp_cnt[5] & 255, "R4 first snapshot");
    old = exp_cnt[5];
    viol[5] = 1'b1;
    repeat (10) cyc();
    viol = '0;
    wr(2'd1, 8'h02);
    cyc();
    rd(2'd2, v); chk(v, old & 255, "R4 no reload while bit stays 1");
    read_count(5, v);
    chk(v, old + 10, "R4 counting continued");

    // R8: out-of-range select
    read_count(1, old);
    for (int s = 14; s <= 15; s++) begin
      wr(2'd0, 8'(s));
      wr(2'd1, 8'h02);
      cyc();
      rd(2'd2, v); chk(v, old & 255, $sformatf("R8 snapshot sel%0d", s));
      wr(2'd1, 8'h00);
      hold_clear(s, HC + 6);
    end
    check_all("R8 clear ignored");

    // R6: one cycle short of the hold time
    hold_clear(2, HC - 1);
    check_all("R6 short clear");

    // R6 / R7 / R10: exact hold time with a pulse at every cycle
    viol[2] = 1'b1;
    hold_clear(2, HC);
    viol = '0;
    exp_cnt[2] = 0;
    check_all("R7 clear beats pulse");

    // R3: saturation on every channel
    viol = '1;
    repeat (65540) cyc();
    viol = '0;
    check_all("R3 saturate");
    read_count(9, v);
    chk(v >> 8, 255, "R3 R5 high byte saturated");
    viol[0] = 1'b1;
    repeat (5) cyc();
    viol = '0;
    read_count(0, v); chk(v, CMAX, "R3 no wrap");
    hold_clear(0, HC);
    exp_cnt[0] = 0;
    check_all("R6 R10 clear after saturation");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule